// File: doc/BRIEF.md
# Stacked-Die Thermal Gradient Throttle Controller

This block looks at a grid of temperature readings taken across a stack of dies and decides which grid cells should have their power reduced. Once per sampling interval, an external scheduler pulses `start`. The block then reads every sensor through a one-cycle-latency read port. It begins with the lowest layer, finishes that layer, and then moves up one layer at a time. Each sample is stored locally.

When the whole stack has been read, the block evaluates every neighbour pair in one step. Each pair is a directed temperature difference, treated as a force that points from the hotter cell to the cooler one. Two kinds of pair are checked:

- **Same-layer pairs.** These are compared against a lateral limit.
- **Vertically stacked pairs.** These are compared against a vertical limit. The block also checks whether the force direction reverses going up a column.

A cell is requested for throttling when it is the hotter member of a pair whose difference is too large. It is also requested when it is the hotter member of any directed pair in a column whose force direction flips back and forth through the stack.

The result is a throttle bitmap, a one-cycle done pulse and an equilibrium flag. The flag reports that the pass just completed marked no cell. Power management repeats the pass each interval until equilibrium is reached.

Top module: `stack_grad_throttle`

## Requirements
- R1: While reset is high and after it is released, the outputs are as follows until the first accepted start: `throttle` is all zero, `done` and `equilibrium` are low, and `rd_en` is low.
- R2: After an accepted start, the block issues exactly one read per cycle for every cell, LAYERS*ROWS*COLS reads in all. Layer 0 is read first and the top layer last. Within a layer, cells are read in increasing cell index, where cell index = row*COLS + col. `rd_data` is taken as the answer to the read issued in the previous cycle.
- R3: Within a layer, each cell is paired only with its east neighbour (col+1) and its south neighbour (row+1). Cells on the grid edge skip neighbours that do not exist. The difference is the plain difference of the two 12-bit unsigned readings. If its magnitude is strictly greater than `lat_thr`, the hotter cell is marked. A magnitude equal to the limit marks nothing.
- R4: For each cell index, the readings in layers k and k+1 form a vertical pair. If their difference magnitude is strictly greater than `vert_thr`, the hotter cell is marked.
- R5: Each vertical pair is given a direction:
  - up: the lower layer is hotter;
  - down: the upper layer is hotter;
  - none: the readings are equal.

  Moving up a column, a direction that is not none and is opposite to the previous pair's direction counts as a reversal. A pair with direction none resets the reversal count. When the count reaches FLIPS (default 2, i.e. up, down, up), the hotter cell of every directed pair in that column is marked, whatever the limits.
- R6: `throttle` bit layer*ROWS*COLS + row*COLS + col is the throttle request of that cell. The bitmap is cleared in the cycle after an accepted start. It is loaded when `done` rises, and holds its value from then until the next accepted start.
- R7: `done` is high for exactly one cycle at the end of each pass. In that same cycle, `equilibrium` goes high if and only if no bit of `throttle` is set. `equilibrium` is cleared by an accepted start and otherwise holds its value.
- R8: A `start` that arrives while a pass is running is ignored. It does not restart the scan, shift the read sequence or cause an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass when the block is idle |
| lat_thr | input | TW | Limit for in-layer difference magnitude |
| vert_thr | input | TW | Limit for layer-to-layer difference magnitude |
| rd_en | output | 1 | Sensor read request |
| rd_layer | output | LW | Layer of the requested sensor |
| rd_cell | output | CW | Cell index (row*COLS+col) of the requested sensor |
| rd_data | input | TW | Sensor reading, valid one cycle after the request |
| throttle | output | LAYERS*ROWS*COLS | Per-cell throttle request bitmap |
| done | output | 1 | One-cycle pulse at the end of a pass |
| equilibrium | output | 1 | Last completed pass marked no cell |

## Verification
The assertions rely on a few properties of the inputs:

- `rd_data` always answers the request of the previous cycle.
- `start` is a single-cycle pulse.
- The two limits stay fixed for the whole duration of a pass.

The bench meets these as follows. Its sensor model registers the addressed reading on every requested cycle. It raises `start` for exactly one cycle. It changes the limits and the grid contents only between passes, after `done` has been seen. The deliberate overlapping start is issued while the read sequence is in progress, so that only the ignoring rule is exercised.

// File: rtl/gt_pkg.sv
package gt_pkg;
  typedef enum logic [1:0] {
    VD_NONE = 2'd0,
    VD_UP   = 2'd1,
    VD_DOWN = 2'd2
  } vdir_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_DRAIN,
    ST_EVAL
  } scan_st_t;
endpackage

// File: rtl/gt_scan_ctrl.sv
module gt_scan_ctrl
  import gt_pkg::*;
#(
  parameter int LAYERS = 4,
  parameter int CELLS  = 16,
  localparam int LW = (LAYERS > 1) ? $clog2(LAYERS) : 1,
  localparam int CW = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int AW = (LAYERS * CELLS > 1) ? $clog2(LAYERS * CELLS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          eval_fire,
  output logic          rd_en,
  output logic [LW-1:0] rd_layer,
  output logic [CW-1:0] rd_cell,
  output logic          cap_en,
  output logic [AW-1:0] cap_idx
);
  scan_st_t state_q;

  assign busy      = (state_q != ST_IDLE);
  assign eval_fire = (state_q == ST_EVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      rd_en    <= 1'b0;
      rd_layer <= '0;
      rd_cell  <= '0;
      cap_en   <= 1'b0;
      cap_idx  <= '0;
    end else begin
      // capture pipeline follows the request by one cycle
      cap_en  <= rd_en;
      cap_idx <= AW'(rd_layer) * AW'(CELLS) + AW'(rd_cell);
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q  <= ST_READ;
            rd_en    <= 1'b1;
            rd_layer <= '0;
            rd_cell  <= '0;
          end
        end
        ST_READ: begin
          if (rd_cell == CW'(CELLS - 1)) begin
            rd_cell <= '0;
            if (rd_layer == LW'(LAYERS - 1)) begin
              rd_en   <= 1'b0;
              state_q <= ST_DRAIN;
            end else begin
              rd_layer <= rd_layer + 1'b1;
            end
          end else begin
            rd_cell <= rd_cell + 1'b1;
          end
        end
        ST_DRAIN: state_q <= ST_EVAL;
        ST_EVAL:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && $past(rd_en) && ($past(rd_cell) != CW'(CELLS - 1))
      |-> (rd_cell == $past(rd_cell) + 1'b1) && (rd_layer == $past(rd_layer)));

  // R2
  scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && $past(rd_en) && ($past(rd_cell) == CW'(CELLS - 1))
      |-> (rd_cell == '0) && (rd_layer == $past(rd_layer) + 1'b1));

  // R8
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> !(rd_en && rd_layer == '0 && rd_cell == '0));
endmodule

// File: rtl/gt_grid_store.sv
module gt_grid_store #(
  parameter int TOT = 64,
  parameter int TW  = 12,
  localparam int AW = (TOT > 1) ? $clog2(TOT) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [TW-1:0]     wdata,
  output logic [TOT*TW-1:0] grid_flat
);
  logic [TW-1:0] cells_q [TOT];

  always_ff @(posedge clk) begin
    if (we) cells_q[waddr] <= wdata;
  end

  for (genvar i = 0; i < TOT; i++) begin : g_out
    assign grid_flat[i*TW +: TW] = cells_q[i];
  end
endmodule

// File: rtl/gt_lateral_eval.sv
module gt_lateral_eval #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int TW   = 12
) (
  input  logic [ROWS*COLS*TW-1:0] layer_flat,
  input  logic [TW-1:0]           thr,
  output logic [ROWS*COLS-1:0]    mark
);
  function automatic logic exceeds(input logic [TW-1:0] a, input logic [TW-1:0] b,
                                   input logic [TW-1:0] lim);
    logic [TW:0] d;
    logic [TW:0] mag;
    d   = {1'b0, a} - {1'b0, b};
    mag = d[TW] ? (~d + 1'b1) : d;
    return mag > {1'b0, lim};
  endfunction

  always_comb begin
    logic [TW-1:0] here;
    logic [TW-1:0] nb;
    mark = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        here = layer_flat[(r*COLS + c)*TW +: TW];
        if (c + 1 < COLS) begin
          nb = layer_flat[(r*COLS + c + 1)*TW +: TW];
          if (exceeds(here, nb, thr)) begin
            if (here > nb) mark[r*COLS + c] = 1'b1;
            else           mark[r*COLS + c + 1] = 1'b1;
          end
        end
        if (r + 1 < ROWS) begin
          nb = layer_flat[((r + 1)*COLS + c)*TW +: TW];
          if (exceeds(here, nb, thr)) begin
            if (here > nb) mark[r*COLS + c] = 1'b1;
            else           mark[(r + 1)*COLS + c] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/gt_column_eval.sv
module gt_column_eval
  import gt_pkg::*;
#(
  parameter int LAYERS = 4,
  parameter int TW     = 12,
  parameter int FLIPS  = 2
) (
  input  logic [LAYERS*TW-1:0] col_flat,
  input  logic [TW-1:0]        thr,
  output logic [LAYERS-1:0]    mark
);
  localparam int NP = LAYERS - 1;

  vdir_t       dir_v [NP];
  logic [NP-1:0] big_v;
  logic        alt;

  always_comb begin
    logic [TW-1:0] lo;
    logic [TW-1:0] hi;
    logic [TW:0]   d;
    logic [TW:0]   mag;
    vdir_t         prev;
    int            run;
    mark = '0;
    alt  = 1'b0;
    prev = VD_NONE;
    run  = 0;
    for (int p = 0; p < NP; p++) begin
      lo  = col_flat[p*TW +: TW];
      hi  = col_flat[(p + 1)*TW +: TW];
      d   = {1'b0, lo} - {1'b0, hi};
      mag = d[TW] ? (~d + 1'b1) : d;
      big_v[p] = mag > {1'b0, thr};
      if (lo > hi)      dir_v[p] = VD_UP;
      else if (hi > lo) dir_v[p] = VD_DOWN;
      else              dir_v[p] = VD_NONE;
      // run length of alternating directed pairs
      if (dir_v[p] == VD_NONE)                      run = 0;
      else if (prev != VD_NONE && dir_v[p] != prev) run = run + 1;
      else                                          run = 1;
      if (run >= FLIPS + 1) alt = 1'b1;
      prev = dir_v[p];
    end
    for (int p = 0; p < NP; p++) begin
      if (dir_v[p] != VD_NONE && (big_v[p] || alt)) begin
        if (dir_v[p] == VD_UP) mark[p] = 1'b1;
        else                   mark[p + 1] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/stack_grad_throttle.sv
module stack_grad_throttle #(
  parameter int LAYERS = 4,
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int TW     = 12,
  parameter int FLIPS  = 2,
  localparam int LW = (LAYERS > 1) ? $clog2(LAYERS) : 1,
  localparam int CW = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1,
  localparam int NB = LAYERS * ROWS * COLS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] lat_thr,
  input  logic [TW-1:0] vert_thr,
  output logic          rd_en,
  output logic [LW-1:0] rd_layer,
  output logic [CW-1:0] rd_cell,
  input  logic [TW-1:0] rd_data,
  output logic [NB-1:0] throttle,
  output logic          done,
  output logic          equilibrium
);
  localparam int CELLS = ROWS * COLS;
  localparam int AW    = (NB > 1) ? $clog2(NB) : 1;

  logic             busy;
  logic             eval_fire;
  logic             cap_en;
  logic [AW-1:0]    cap_idx;
  logic [NB*TW-1:0] grid_flat;
  logic [NB-1:0]    lat_mark;
  logic [NB-1:0]    vert_mark;
  logic [NB-1:0]    mark_all;
  logic             accept;

  gt_scan_ctrl #(.LAYERS(LAYERS), .CELLS(CELLS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .eval_fire(eval_fire),
    .rd_en(rd_en), .rd_layer(rd_layer), .rd_cell(rd_cell),
    .cap_en(cap_en), .cap_idx(cap_idx)
  );

  gt_grid_store #(.TOT(NB), .TW(TW)) u_store (
    .clk(clk), .we(cap_en), .waddr(cap_idx), .wdata(rd_data), .grid_flat(grid_flat)
  );

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    gt_lateral_eval #(.ROWS(ROWS), .COLS(COLS), .TW(TW)) u_lat (
      .layer_flat(grid_flat[l*CELLS*TW +: CELLS*TW]),
      .thr(lat_thr),
      .mark(lat_mark[l*CELLS +: CELLS])
    );
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_col
    logic [LAYERS*TW-1:0] colv;
    logic [LAYERS-1:0]    cmark;
    for (genvar l = 0; l < LAYERS; l++) begin : g_lv
      assign colv[l*TW +: TW]      = grid_flat[(l*CELLS + i)*TW +: TW];
      assign vert_mark[l*CELLS + i] = cmark[l];
    end
    gt_column_eval #(.LAYERS(LAYERS), .TW(TW), .FLIPS(FLIPS)) u_vert (
      .col_flat(colv), .thr(vert_thr), .mark(cmark)
    );
  end

  assign mark_all = lat_mark | vert_mark;
  assign accept   = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      throttle    <= '0;
      done        <= 1'b0;
      equilibrium <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        throttle    <= '0;
        equilibrium <= 1'b0;
      end
      if (eval_fire) begin
        throttle    <= mark_all;
        done        <= 1'b1;
        equilibrium <= (mark_all == '0);
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  eq_clean_chk: assert property (@(posedge clk) disable iff (rst)
    equilibrium |-> (throttle == '0));

  // R6
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept && !eval_fire |=> $stable(throttle));

  // R6
  map_clear_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (throttle == '0) && !equilibrium);
endmodule

// File: tb/stack_grad_throttle_tb.sv
module stack_grad_throttle_tb;
  localparam int L = 4, R = 4, C = 4, TW = 12, CELLS = R * C, TOT = L * CELLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [TW-1:0] lat_thr = '0, vert_thr = '0;
  logic rd_en;
  logic [1:0] rd_layer;
  logic [3:0] rd_cell;
  logic [TW-1:0] rd_data = '0;
  logic [TOT-1:0] throttle;
  logic done, equilibrium;

  logic [TW-1:0] mem [TOT];
  int checks = 0, fails = 0;
  int scan_pos = 0, scan_bad = 0, done_cnt = 0;

  always #5 clk = ~clk;

  stack_grad_throttle #(.LAYERS(L), .ROWS(R), .COLS(C), .TW(TW), .FLIPS(2)) u_dut (
    .clk(clk), .rst(rst), .start(start), .lat_thr(lat_thr), .vert_thr(vert_thr),
    .rd_en(rd_en), .rd_layer(rd_layer), .rd_cell(rd_cell), .rd_data(rd_data),
    .throttle(throttle), .done(done), .equilibrium(equilibrium)
  );

  // sensor model: one cycle read latency
  always @(posedge clk) if (rd_en) rd_data <= mem[int'(rd_layer) * CELLS + int'(rd_cell)];

  always @(posedge clk) begin
    if (rd_en) begin
      if (int'(rd_layer) != scan_pos / CELLS || int'(rd_cell) != scan_pos % CELLS) scan_bad++;
      scan_pos++;
    end
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int cell_at(int l, int r, int c);
    return l * CELLS + r * C + c;
  endfunction

  function automatic logic [TOT-1:0] expect_map(input logic [TW-1:0] lt, input logic [TW-1:0] vt);
    logic [TOT-1:0] m = '0;
    for (int l = 0; l < L; l++)
      for (int r = 0; r < R; r++)
        for (int c = 0; c < C; c++) begin
          int a = int'(mem[cell_at(l, r, c)]);
          if (c < C - 1) begin
            int b = int'(mem[cell_at(l, r, c + 1)]);
            if (a - b > int'(lt)) m[cell_at(l, r, c)] = 1'b1;
            if (b - a > int'(lt)) m[cell_at(l, r, c + 1)] = 1'b1;
          end
          if (r < R - 1) begin
            int b = int'(mem[cell_at(l, r + 1, c)]);
            if (a - b > int'(lt)) m[cell_at(l, r, c)] = 1'b1;
            if (b - a > int'(lt)) m[cell_at(l, r + 1, c)] = 1'b1;
          end
        end
    for (int i = 0; i < CELLS; i++) begin
      int flips = 0;
      int pd = 0;
      bit alt = 0;
      for (int p = 0; p < L - 1; p++) begin
        int d = int'(mem[p * CELLS + i]) - int'(mem[(p + 1) * CELLS + i]);
        int sd = (d > 0) ? 1 : ((d < 0) ? -1 : 0);
        if (sd == 0) flips = 0;
        else if (pd != 0 && sd != pd) flips++;
        else flips = 0;
        pd = sd;
        if (flips >= 2) alt = 1;
      end
      for (int p = 0; p < L - 1; p++) begin
        int d = int'(mem[p * CELLS + i]) - int'(mem[(p + 1) * CELLS + i]);
        if (d > 0 && (d > int'(vt) || alt)) m[p * CELLS + i] = 1'b1;
        if (d < 0 && (-d > int'(vt) || alt)) m[(p + 1) * CELLS + i] = 1'b1;
      end
    end
    return m;
  endfunction

  task automatic fill(input int v);
    for (int i = 0; i < TOT; i++) mem[i] = TW'(v);
  endtask

  task automatic run_pass(input string req, input bit poke);
    logic [TOT-1:0] e;
    int d0;
    int w;
    e = expect_map(lat_thr, vert_thr);
    scan_pos = 0;
    scan_bad = 0;
    d0 = done_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    w = 0;
    while (!done && w < 1000) begin
      @(negedge clk);
      w++;
    end
    chk(done, req, "done reached", 64'(done), 64'd1);
    chk(throttle == e, req, "throttle map", 64'(throttle), 64'(e));
    chk(equilibrium == (e == '0), "R7", "equilibrium", 64'(equilibrium), 64'(e == '0));
    chk(scan_pos == TOT && scan_bad == 0, "R2", "scan order (reads, bad)",
        64'(scan_pos), 64'(TOT));
    @(negedge clk);
    chk(!done, "R7", "done one cycle", 64'(done), 64'd0);
    if (poke) begin
      repeat (TOT + 10) @(negedge clk);
      chk(done_cnt == d0 + 1, "R8", "done count after overlapping start",
          64'(done_cnt - d0), 64'd1);
      chk(throttle == e, "R6", "map held after done", 64'(throttle), 64'(e));
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    fill(1000);
    repeat (4) @(negedge clk);
    chk(throttle == '0 && !done && !equilibrium && !rd_en, "R1", "reset outputs",
        64'({throttle != '0, done, equilibrium, rd_en}), 64'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(throttle == '0 && !done && !equilibrium && !rd_en, "R1", "idle after reset",
        64'({throttle != '0, done, equilibrium, rd_en}), 64'd0);

    lat_thr = 12'd50;
    vert_thr = 12'd50;
    // uniform stack: nothing marked, equilibrium
    run_pass("R7", 1'b0);
    chk(equilibrium, "R7", "uniform equilibrium", 64'(equilibrium), 64'd1);

    // single hotspot over both limits
    mem[cell_at(1, 1, 1)] = 12'd1051;
    run_pass("R3", 1'b0);
    chk(throttle == (64'd1 << cell_at(1, 1, 1)), "R3", "hotspot bit index",
        64'(throttle), 64'd1 << cell_at(1, 1, 1));

    // magnitude equal to the limit marks nothing
    mem[cell_at(1, 1, 1)] = 12'd1050;
    run_pass("R3", 1'b0);
    chk(throttle == '0, "R3", "equal to limit", 64'(throttle), 64'd0);

    // cold corner on the grid edge: hotter neighbours are marked
    fill(1000);
    mem[cell_at(3, 3, 3)] = 12'd900;
    run_pass("R4", 1'b0);

    // alternating column below both limits: up, down, up
    fill(1000);
    mem[cell_at(0, 1, 1)] = 12'd1010;
    mem[cell_at(2, 1, 1)] = 12'd1010;
    run_pass("R5", 1'b0);
    chk(throttle == ((64'd1 << cell_at(0, 1, 1)) | (64'd1 << cell_at(2, 1, 1))), "R5",
        "alternation marks", 64'(throttle),
        (64'd1 << cell_at(0, 1, 1)) | (64'd1 << cell_at(2, 1, 1)));
    chk(!equilibrium, "R7", "no equilibrium after marks", 64'(equilibrium), 64'd0);

    // equal pair breaks the run: up, none, up
    fill(1000);
    mem[cell_at(0, 2, 0)] = 12'd1010;
    mem[cell_at(3, 2, 0)] = 12'd990;
    run_pass("R5", 1'b0);

    // only one reversal: up, down, none
    fill(1000);
    mem[cell_at(0, 0, 2)] = 12'd1010;
    mem[cell_at(2, 0, 2)] = 12'd1010;
    mem[cell_at(3, 0, 2)] = 12'd1010;
    run_pass("R5", 1'b0);

    // extreme readings against extreme limits
    fill(0);
    mem[cell_at(2, 0, 0)] = 12'd4095;
    lat_thr = 12'd4094;
    vert_thr = 12'd4094;
    run_pass("R4", 1'b0);
    lat_thr = 12'd4095;
    vert_thr = 12'd4095;
    run_pass("R3", 1'b0);

    // overlapping start is ignored, map holds
    fill(500);
    mem[cell_at(1, 2, 3)] = 12'd700;
    lat_thr = 12'd100;
    vert_thr = 12'd150;
    run_pass("R8", 1'b1);

    // random stacks
    for (int k = 0; k < 20; k++) begin
      lat_thr = TW'($urandom_range(4, 40));
      vert_thr = TW'($urandom_range(4, 40));
      for (int i = 0; i < TOT; i++) mem[i] = TW'(2000 + $urandom_range(0, 60));
      run_pass("R3", (k % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule